// File: doc/BRIEF.md
# Split-Mode Reload Timer with Capture

This block is a timer and capture unit with a 16-bit count. It works either as one 16-bit counter or as two 8-bit halves that run on their own. In split mode each half has its own run bit, its own count source and its own choice of mode. In timer mode a half reloads itself from a reload register when it rolls over. In capture mode a half records its running count into that register when the capture input gives an edge. The two halves share one capture-event input and one interrupt line. Software writes to a small byte-wide register port. Two slow strobes from outside the block give the low-rate count sources.

Each half picks its count source from four choices: the system clock, the system clock divided by a parameter (12 by default), a tick strobe and a pulse strobe. Every source acts as a count enable of one cycle in the system-clock domain. A flag set by an overflow or a capture stays set until software clears it. The interrupt output combines the two flags through their enables.

Top module: `split_reload_timer`

## Requirements
- R1: After a synchronous reset, the counter, the reload register, both flags, the interrupt and all control fields are zero.
- R2: A write takes effect on the clock edge it is presented on. Address 0 is control: bit0 split, bit1 low-half capture mode, bit2 high-half capture mode, bit3 low run, bit4 high run, bit5 low flag, bit6 high flag, bit7 low-flag interrupt enable. Address 1 is source: bits1:0 low source, bits3:2 high source, bit4 global interrupt enable. Addresses 2 and 3 are the reload low and high bytes. Addresses 4 and 5 are the count low and high bytes. A count write overrides counting and reloading in that cycle.
- R3: Source code 0 gives one enable every 12 system cycles, counted from reset. Code 1 follows the tick strobe, code 2 follows the pulse strobe, and code 3 enables every cycle.
- R4: A half whose run bit is clear keeps its count.
- R5: In split mode, an enabled timer half at 0xFF loads its reload byte on the next edge and sets its own flag. Otherwise an enabled half increments.
- R6: The capture input passes through two synchronizer stages and an edge detector. A rising edge acts on the third clock edge after it is sampled. A half in capture mode copies its current count into its reload byte and sets its flag. It keeps counting and wraps from 0xFF to 0x00 without reloading and without setting the flag.
- R7: In wide mode the 16-bit counter uses the low half's source, run and capture bits. An enabled count of 0xFFFF loads the 16-bit reload value and sets the high flag.
- R8: In wide capture mode a capture edge copies all 16 count bits into the reload register and sets the high flag. The count keeps running and wraps freely.
- R9: A flag stays set until a control write puts 0 in its bit. A hardware set in the same cycle as that write wins.
- R10: The interrupt equals the global enable AND (high flag OR (low flag AND low enable)). It is registered and changes on the same edge as the flags and enables.
- R11: When a capture and a software reload write hit the same half in one cycle, the captured count is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Write data byte |
| tick_stb | input | 1 | Tick strobe, one cycle wide |
| pulse_stb | input | 1 | Pulse strobe, one cycle wide |
| cap_in | input | 1 | Capture event, asynchronous |
| count_o | output | 16 | Counter, high byte above low byte |
| reload_o | output | 16 | Reload/capture register |
| flag_lo_o | output | 1 | Low-half overflow/capture flag |
| flag_hi_o | output | 1 | High-half (or wide) overflow/capture flag |
| irq_o | output | 1 | Combined interrupt |

## Verification
A wrong count-enable decision shows on count_o at the very next edge. An off-by-one in the divide-by-12 source therefore shows within 12 cycles. A wrong reload or capture shows on count_o or reload_o at the edge after the event. A misrouted flag or enable shows on irq_o in that same cycle. A reference model is compared with every output on every clock. Any internal divergence is therefore reported in the cycle it first reaches a port.

// File: rtl/tmr_split_pkg.sv
package tmr_split_pkg;

  typedef enum logic [1:0] {
    SRC_DIV   = 2'd0,
    SRC_TICK  = 2'd1,
    SRC_PULSE = 2'd2,
    SRC_SYS   = 2'd3
  } src_e;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_SRC    = 3'd1;
  localparam logic [2:0] A_RLD_LO = 3'd2;
  localparam logic [2:0] A_RLD_HI = 3'd3;
  localparam logic [2:0] A_CNT_LO = 3'd4;
  localparam logic [2:0] A_CNT_HI = 3'd5;

  function automatic logic src_pick(src_e s, logic d, logic t, logic p);
    case (s)
      SRC_DIV:   return d;
      SRC_TICK:  return t;
      SRC_PULSE: return p;
      default:   return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/tmr_strobes.sv
module tmr_strobes #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic cap_in,
  output logic div_stb,
  output logic cap_evt
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q;
  logic [2:0]    sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      sync_q <= '0;
    end else begin
      div_q  <= (div_q == LAST) ? '0 : div_q + 1'b1;
      sync_q <= {sync_q[1:0], cap_in};
    end
  end

  assign div_stb = (div_q == LAST);
  assign cap_evt = sync_q[1] & ~sync_q[2];

  AST_DIV_SPACING: assert property (@(posedge clk) disable iff (rst)
    div_stb |=> !div_stb); // R3
  AST_CAP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> !cap_evt); // R6
endmodule

// File: rtl/tmr_half.sv
module tmr_half #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_cnt,
  input  logic         wr_rld,
  input  logic [W-1:0] wdata,
  input  logic         inc,
  input  logic         load,
  input  logic         cap,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] rld_o
);
  logic [W-1:0] cnt_q, rld_q, cnt_n, rld_n;

  always_comb begin
    if (wr_cnt)    cnt_n = wdata;
    else if (load) cnt_n = rld_q;
    else if (inc)  cnt_n = cnt_q + 1'b1;
    else           cnt_n = cnt_q;
    if (cap)         rld_n = cnt_q;
    else if (wr_rld) rld_n = wdata;
    else             rld_n = rld_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      rld_q <= rld_n;
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;

  AST_HALF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_cnt && !load && !inc) |=> $stable(cnt_o)); // R4
  AST_CAP_WINS: assert property (@(posedge clk) disable iff (rst)
    (cap && wr_rld) |=> (rld_o == $past(cnt_o))); // R11
endmodule

// File: rtl/split_reload_timer.sv
module split_reload_timer
  import tmr_split_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int DIV    = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [2:0]            wr_addr,
  input  logic [7:0]            wr_data,
  input  logic                  tick_stb,
  input  logic                  pulse_stb,
  input  logic                  cap_in,
  output logic [2*HALF_W-1:0]   count_o,
  output logic [2*HALF_W-1:0]   reload_o,
  output logic                  flag_lo_o,
  output logic                  flag_hi_o,
  output logic                  irq_o
);
  localparam int CW = 2 * HALF_W;

  logic div_stb, cap_evt;
  logic split_q, loie_q, gie_q, irq_q;
  logic [1:0] capm_q, run_q, flag_q;
  src_e [1:0] sel_q;

  logic [1:0][HALF_W-1:0] cnt_h, rld_h;
  logic [1:0] en, mx, inc, load, cap, set;
  logic ctrl_wr, src_wr;
  logic split_n, loie_n, gie_n;
  logic [1:0] capm_n, run_n, flag_n;
  src_e [1:0] sel_n;
  logic wrap16;

  tmr_strobes #(.DIV(DIV)) strobes_i (
    .clk(clk), .rst(rst), .cap_in(cap_in),
    .div_stb(div_stb), .cap_evt(cap_evt)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam logic [2:0] CA = (h == 0) ? A_CNT_LO : A_CNT_HI;
    localparam logic [2:0] RA = (h == 0) ? A_RLD_LO : A_RLD_HI;
    assign en[h] = run_q[h] & src_pick(sel_q[h], div_stb, tick_stb, pulse_stb);
    assign mx[h] = (cnt_h[h] == {HALF_W{1'b1}});
    tmr_half #(.W(HALF_W)) half_i (
      .clk(clk), .rst(rst),
      .wr_cnt(wr_en && wr_addr == CA),
      .wr_rld(wr_en && wr_addr == RA),
      .wdata(wr_data[HALF_W-1:0]),
      .inc(inc[h]), .load(load[h]), .cap(cap[h]),
      .cnt_o(cnt_h[h]), .rld_o(rld_h[h])
    );
  end

  // mode decode: which half counts, reloads or captures this cycle
  always_comb begin
    inc    = '0;
    load   = '0;
    cap    = '0;
    set    = '0;
    wrap16 = en[0] & mx[0] & mx[1];
    if (split_q) begin
      for (int h = 0; h < 2; h++) begin
        if (capm_q[h]) begin
          inc[h] = en[h];
          cap[h] = cap_evt;
          set[h] = cap_evt;
        end else begin
          load[h] = en[h] & mx[h];
          inc[h]  = en[h] & ~mx[h];
          set[h]  = en[h] & mx[h];
        end
      end
    end else if (capm_q[0]) begin
      inc[0] = en[0];
      inc[1] = en[0] & mx[0];
      cap    = {cap_evt, cap_evt};
      set[1] = cap_evt;
    end else begin
      load   = {wrap16, wrap16};
      inc[0] = en[0] & ~wrap16;
      inc[1] = en[0] & mx[0] & ~wrap16;
      set[1] = wrap16;
    end
  end

  // control and flag next state
  always_comb begin
    ctrl_wr = wr_en && (wr_addr == A_CTRL);
    src_wr  = wr_en && (wr_addr == A_SRC);
    split_n = ctrl_wr ? wr_data[0]   : split_q;
    capm_n  = ctrl_wr ? wr_data[2:1] : capm_q;
    run_n   = ctrl_wr ? wr_data[4:3] : run_q;
    loie_n  = ctrl_wr ? wr_data[7]   : loie_q;
    flag_n  = set | (ctrl_wr ? wr_data[6:5] : flag_q);
    sel_n[0] = src_wr ? src_e'(wr_data[1:0]) : sel_q[0];
    sel_n[1] = src_wr ? src_e'(wr_data[3:2]) : sel_q[1];
    gie_n   = src_wr ? wr_data[4] : gie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      split_q <= 1'b0;
      capm_q  <= '0;
      run_q   <= '0;
      loie_q  <= 1'b0;
      flag_q  <= '0;
      sel_q   <= {SRC_DIV, SRC_DIV};
      gie_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      split_q <= split_n;
      capm_q  <= capm_n;
      run_q   <= run_n;
      loie_q  <= loie_n;
      flag_q  <= flag_n;
      sel_q   <= sel_n;
      gie_q   <= gie_n;
      irq_q   <= gie_n & (flag_n[1] | (flag_n[0] & loie_n));
    end
  end

  assign count_o   = {cnt_h[1], cnt_h[0]};
  assign reload_o  = {rld_h[1], rld_h[0]};
  assign flag_lo_o = flag_q[0];
  assign flag_hi_o = flag_q[1];
  assign irq_o     = irq_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_lo_o && !ctrl_wr) |=> flag_lo_o); // R9
  AST_SPLIT_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (split_q && !capm_q[0] && en[0] && cnt_h[0] == {HALF_W{1'b1}}
     && !(wr_en && wr_addr == A_CNT_LO))
    |=> (count_o[HALF_W-1:0] == $past(reload_o[HALF_W-1:0])) && flag_lo_o); // R5
  AST_SPLIT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (split_q && capm_q[0] && cap_evt)
    |=> (reload_o[HALF_W-1:0] == $past(count_o[HALF_W-1:0])) && flag_lo_o); // R6
  AST_WIDE_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (!split_q && !capm_q[0] && en[0] && count_o == {CW{1'b1}}
     && !(wr_en && (wr_addr == A_CNT_LO || wr_addr == A_CNT_HI)))
    |=> (count_o == $past(reload_o)) && flag_hi_o); // R7
  AST_WIDE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!split_q && capm_q[0] && cap_evt) |=> (reload_o == $past(count_o)) && flag_hi_o); // R8
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (flag_hi_o || flag_lo_o)); // R10
endmodule

// File: tb/split_reload_timer_tb.sv
module split_reload_timer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic tick_stb = 1'b0, pulse_stb = 1'b0, cap_in = 1'b0;
  logic [15:0] count_o, reload_o;
  logic flag_lo_o, flag_hi_o, irq_o;

  always #4 clk = ~clk;

  split_reload_timer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick_stb(tick_stb), .pulse_stb(pulse_stb), .cap_in(cap_in),
    .count_o(count_o), .reload_o(reload_o),
    .flag_lo_o(flag_lo_o), .flag_hi_o(flag_hi_o), .irq_o(irq_o)
  );

  int checks = 0, errors = 0;
  string req = "R1";
  bit done = 0;
  int tick_pct = 0, pulse_pct = 0, cap_pct = 0;

  // behavioural reference state
  int mc[2], mr[2], msel[2], dv;
  bit mf[2], mcap[2], mrun[2], msplit, mloie, mgie, mirq, s1, s2, s3;

  task automatic model_reset();
    for (int h = 0; h < 2; h++) begin
      mc[h] = 0; mr[h] = 0; msel[h] = 0; mf[h] = 0; mcap[h] = 0; mrun[h] = 0;
    end
    msplit = 0; mloie = 0; mgie = 0; mirq = 0; s1 = 0; s2 = 0; s3 = 0; dv = 0;
  endtask

  task automatic model_step();
    bit evt, dstb, src, en[2], setf[2], capd[2];
    int nc[2], nr[2], c16, r16;
    evt = s2 && !s3; s3 = s2; s2 = s1; s1 = cap_in;
    dstb = (dv == 11); dv = dstb ? 0 : dv + 1;
    for (int h = 0; h < 2; h++) begin
      case (msel[h])
        0: src = dstb;
        1: src = tick_stb;
        2: src = pulse_stb;
        default: src = 1;
      endcase
      en[h] = mrun[h] && src;
      nc[h] = mc[h]; nr[h] = mr[h]; setf[h] = 0; capd[h] = 0;
    end
    if (msplit) begin
      for (int h = 0; h < 2; h++) begin
        if (mcap[h]) begin
          if (evt) begin nr[h] = mc[h]; setf[h] = 1; capd[h] = 1; end
          if (en[h]) nc[h] = (mc[h] + 1) % 256;
        end else if (en[h]) begin
          if (mc[h] == 255) begin nc[h] = mr[h]; setf[h] = 1; end
          else nc[h] = mc[h] + 1;
        end
      end
    end else begin
      c16 = mc[1] * 256 + mc[0]; r16 = mr[1] * 256 + mr[0];
      if (mcap[0]) begin
        if (evt) begin nr[0] = mc[0]; nr[1] = mc[1]; setf[1] = 1; capd[0] = 1; capd[1] = 1; end
        if (en[0]) c16 = (c16 + 1) % 65536;
      end else if (en[0]) begin
        if (c16 == 65535) begin c16 = r16; setf[1] = 1; end
        else c16 = c16 + 1;
      end
      nc[0] = c16 % 256; nc[1] = c16 / 256;
    end
    for (int h = 0; h < 2; h++) mf[h] = mf[h] | setf[h];
    if (wr_en) begin
      case (wr_addr)
        3'd0: begin
          msplit = wr_data[0]; mcap[0] = wr_data[1]; mcap[1] = wr_data[2];
          mrun[0] = wr_data[3]; mrun[1] = wr_data[4]; mloie = wr_data[7];
          mf[0] = setf[0] | wr_data[5]; mf[1] = setf[1] | wr_data[6];
        end
        3'd1: begin msel[0] = wr_data[1:0]; msel[1] = wr_data[3:2]; mgie = wr_data[4]; end
        3'd2: if (!capd[0]) nr[0] = wr_data;
        3'd3: if (!capd[1]) nr[1] = wr_data;
        3'd4: nc[0] = wr_data;
        3'd5: nc[1] = wr_data;
        default: ;
      endcase
    end
    for (int h = 0; h < 2; h++) begin mc[h] = nc[h]; mr[h] = nr[h]; end
    mirq = mgie && (mf[1] || (mf[0] && mloie));
  endtask

  always @(posedge clk) begin
    if (rst) model_reset(); else model_step();
    #2;
    checks++;
    if (count_o !== 16'(mc[1] * 256 + mc[0]) || reload_o !== 16'(mr[1] * 256 + mr[0]) ||
        flag_lo_o !== mf[0] || flag_hi_o !== mf[1] || irq_o !== mirq) begin
      errors++;
      $display("FAIL %s t=%0t actual cnt=%h rld=%h fl=%b fh=%b irq=%b expected cnt=%h rld=%h fl=%b fh=%b irq=%b",
               req, $time, count_o, reload_o, flag_lo_o, flag_hi_o, irq_o,
               16'(mc[1] * 256 + mc[0]), 16'(mr[1] * 256 + mr[0]), mf[0], mf[1], mirq);
    end
  end

  // background strobes and capture toggling
  always @(negedge clk) begin
    tick_stb  <= ($urandom % 100) < tick_pct;
    pulse_stb <= ($urandom % 100) < pulse_pct;
    if (($urandom % 100) < cap_pct) cap_in <= ~cap_in;
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    req = "R1"; idle(4); rst = 0; idle(4);
    req = "R2";
    wr(3'd4, 8'h12); wr(3'd5, 8'h34); wr(3'd2, 8'h56); wr(3'd3, 8'h78); idle(3);
    req = "R5";
    wr(3'd2, 8'hF0); wr(3'd4, 8'hFA); wr(3'd3, 8'h80); wr(3'd5, 8'hFE);
    wr(3'd1, 8'b0000_0011);            // low: system clock, high: divide
    wr(3'd0, 8'b0001_1001);            // split, both run
    idle(80);
    req = "R3";
    tick_pct = 30; pulse_pct = 10;
    wr(3'd1, 8'b0000_1001);            // low tick, high pulse
    idle(150);
    req = "R4";
    wr(3'd0, 8'b0000_0001);            // split, nothing runs
    idle(40);
    req = "R9";
    wr(3'd1, 8'b0000_0011);
    wr(3'd4, 8'hFD);
    wr(3'd0, 8'b0110_1001);            // run low, flags kept
    idle(2);
    wr(3'd0, 8'b0000_1001);            // clear flags
    idle(20);
    req = "R10";
    wr(3'd1, 8'b0001_0011);            // global enable
    idle(10);
    wr(3'd0, 8'b1010_1001);            // low enable with low flag
    idle(10);
    wr(3'd0, 8'b0000_1001);
    idle(10);
    req = "R6";
    wr(3'd0, 8'b0001_1011);            // split, low capture, both run
    cap_pct = 10;
    idle(300);
    req = "R7";
    cap_pct = 0;
    wr(3'd2, 8'h34); wr(3'd3, 8'h12); wr(3'd4, 8'hF0); wr(3'd5, 8'hFF);
    wr(3'd0, 8'b0000_1000);            // wide, run, timer
    idle(60);
    req = "R8";
    cap_pct = 8;
    wr(3'd0, 8'b0000_1010);            // wide capture
    idle(300);
    req = "R11";
    wr(3'd0, 8'b0000_1011);
    for (int i = 0; i < 300; i++) begin
      wr(3'(2 + ($urandom % 2)), 8'($urandom));
    end
    req = "R2";
    tick_pct = 40; pulse_pct = 20; cap_pct = 10;
    for (int i = 0; i < 1500; i++) begin
      if (($urandom % 4) == 0) wr(3'($urandom % 6), 8'($urandom));
      else idle(1);
    end
    req = "R1";
    @(negedge clk); rst = 1; idle(2); rst = 0; idle(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule